// File: doc/BRIEF.md
# Line-21 Closed Caption Inserter

This block places two caption characters on one chosen video line of one chosen field. It watches a field identifier, a line counter and a pixel counter that advance with a pixel-rate enable. Software stores a character pair through a load port, and the load raises a ready flag. When the programmed line of the programmed field reaches the programmed pixel offset, the block drives a caption burst on a luma override output as plain high and low levels. Analog shaping is left to the stage after it.

The burst opens with a seven-bit clock run-in and a three-bit start sequence. Each character follows with its seven bits, least significant bit first, and then an odd parity bit. Every bit lasts a fixed number of enabled pixels. If no fresh pair is waiting when the caption line arrives, the burst carries a null pair. Once a loaded pair has been sent, the ready flag drops so that software can load the next one.

Top module: `cc_line_inserter`

## Requirements
- R1: After reset, `cc_active`, `cc_level` and `ready` are all 0.
- R2: A burst starts only on a cycle where `pix_en` is 1, `cfg_enable` is 1, `field_id` equals `cfg_field`, `line_num` equals `cfg_line`, `pix_cnt` equals `cfg_hoff`, and no burst is in progress. Any other line, field or offset, or a cleared enable, produces no output.
- R3: A burst has 26 bits, sent in this order. First the run-in 1,0,1,0,1,0,1. Then the start bits 0,0,1. Then the first character with bit 0 first and an odd parity bit. Then the second character in the same form. `cc_level` shows the bit being sent.
- R4: The first bit appears in the cycle after the trigger edge. Each bit lasts exactly `BIT_PIX` edges with `pix_en` high. Cycles with `pix_en` low advance nothing, so a burst spans exactly 26*`BIT_PIX` enabled edges.
- R5: `cc_active` falls at the edge that ends the last bit period. Whenever `cc_active` is 0, `cc_level` is 0.
- R6: A load (`ld_valid` high for one cycle) stores both characters and sets `ready`. If `ready` is 0 at the trigger edge, the burst sends a null pair: two zero characters, each followed by a parity bit of 1.
- R7: After a burst that carried a loaded pair, `ready` goes to 0 at the edge that ends the final bit period.
- R8: A load during a burst, or at its trigger edge, does not change the burst in flight. In that case `ready` stays 1 after the burst ends, and the new pair goes out on the next caption line.
- R9: Clearing `cfg_enable` while a burst is running does not cut the burst short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-rate enable |
| field_id | input | 1 | Current field |
| line_num | input | LINE_W (6) | Current line number |
| pix_cnt | input | PIX_W (11) | Current pixel position in the line |
| cfg_enable | input | 1 | Caption insertion on |
| cfg_field | input | 1 | Field that carries the captions |
| cfg_line | input | LINE_W (6) | Caption line number |
| cfg_hoff | input | HOFF_W (10) | Pixel offset where the burst begins |
| ld_valid | input | 1 | Load strobe for a new character pair |
| ld_char1 | input | 7 | First character |
| ld_char2 | input | 7 | Second character |
| ready | output | 1 | A loaded pair is waiting to be sent |
| cc_active | output | 1 | A caption burst is being driven |
| cc_level | output | 1 | Caption bit level for the luma override |

## Verification
Most internal faults show at the ports within one bit period. A wrong bit index, a stuck sub-bit counter or a misordered frame makes `cc_level` differ from the bench's bit-by-bit model on the first affected pixel. A wrong trigger match shows at once as `cc_active` rising on the wrong line or offset. A mishandled pending flag is different: it shows only at the end of a burst, either as `ready` failing to drop or as a pair that was loaded mid-burst being lost. A wrong parity or null-pair selection appears in the data bits of the next caption line.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int CC_CHAR_W     = 7;
  localparam int CC_RUNIN_BITS = 7;
  localparam int CC_START_BITS = 3;
  localparam int CC_FRAME_BITS = CC_RUNIN_BITS + CC_START_BITS + 2 * (CC_CHAR_W + 1);

  typedef logic [CC_CHAR_W-1:0]     cc_char_t;
  typedef logic [CC_FRAME_BITS-1:0] cc_frame_t;

  // odd parity bit: total ones over char plus parity is odd
  function automatic logic odd_par(cc_char_t c);
    return ~(^c);
  endfunction

  // bit 0 of the result is transmitted first
  function automatic cc_frame_t build_frame(cc_char_t a, cc_char_t b);
    logic [CC_RUNIN_BITS-1:0] runin;
    logic [CC_START_BITS-1:0] strt;
    for (int i = 0; i < CC_RUNIN_BITS; i++) runin[i] = ~i[0];
    strt = {1'b1, {(CC_START_BITS-1){1'b0}}};
    return {odd_par(b), b, odd_par(a), a, strt, runin};
  endfunction
endpackage

// File: rtl/cc_trigger.sv
module cc_trigger #(
  parameter int LINE_W = 6,
  parameter int HOFF_W = 10,
  parameter int PIX_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              field_id,
  input  logic [LINE_W-1:0] line_num,
  input  logic [PIX_W-1:0]  pix_cnt,
  input  logic              cfg_enable,
  input  logic              cfg_field,
  input  logic [LINE_W-1:0] cfg_line,
  input  logic [HOFF_W-1:0] cfg_hoff,
  input  logic              busy,
  output logic              start
);
  logic hit_field, hit_line, hit_pix;

  assign hit_field = (field_id == cfg_field);
  assign hit_line  = (line_num == cfg_line);
  assign hit_pix   = (pix_cnt == PIX_W'(cfg_hoff));
  assign start     = pix_en && cfg_enable && !busy && hit_field && hit_line && hit_pix;

  // R2
  start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/cc_holding.sv
module cc_holding
  import cc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ld_valid,
  input  cc_char_t  ld_char1,
  input  cc_char_t  ld_char2,
  input  logic      start,
  input  logic      last_tick,
  output logic      ready,
  output cc_frame_t frame
);
  cc_char_t c1_q, c2_q;
  logic     pend_q;

  assign frame = build_frame(ready ? c1_q : '0, ready ? c2_q : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready  <= 1'b0;
      pend_q <= 1'b0;
      c1_q   <= '0;
      c2_q   <= '0;
    end else if (ld_valid) begin
      ready  <= 1'b1;
      pend_q <= 1'b0;
      c1_q   <= ld_char1;
      c2_q   <= ld_char2;
    end else begin
      if (start) pend_q <= ready;
      if (last_tick && pend_q) begin
        ready  <= 1'b0;
        pend_q <= 1'b0;
      end
    end
  end

  // R6
  load_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> ready);
  // R7
  clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> ($past(last_tick) && !$past(ld_valid)));
endmodule

// File: rtl/cc_serializer.sv
module cc_serializer
  import cc_pkg::*;
#(
  parameter int BIT_PIX = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pix_en,
  input  logic      start,
  input  cc_frame_t frame,
  output logic      active,
  output logic      level,
  output logic      last_tick
);
  localparam int SUB_W = (BIT_PIX > 1) ? $clog2(BIT_PIX) : 1;
  localparam int IDX_W = $clog2(CC_FRAME_BITS);

  logic [SUB_W-1:0] sub_q;
  logic [IDX_W-1:0] idx_q;
  cc_frame_t        sh_q;
  logic             bit_end;

  assign bit_end   = active && pix_en && (sub_q == SUB_W'(BIT_PIX - 1));
  assign last_tick = bit_end && (idx_q == IDX_W'(CC_FRAME_BITS - 1));
  assign level     = active && sh_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      sub_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
    end else if (start) begin
      active <= 1'b1;
      sub_q  <= '0;
      idx_q  <= '0;
      sh_q   <= frame;
    end else if (active && pix_en) begin
      if (bit_end) begin
        sub_q <= '0;
        if (last_tick) begin
          active <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
          sh_q  <= sh_q >> 1;
        end
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  // R3
  first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && level));
  // R4
  hold_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !pix_en) |=> (active && $stable(level)));
  // R5
  end_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(last_tick));
endmodule

// File: rtl/cc_line_inserter.sv
module cc_line_inserter
  import cc_pkg::*;
#(
  parameter int LINE_W  = 6,
  parameter int HOFF_W  = 10,
  parameter int PIX_W   = 11,
  parameter int BIT_PIX = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pix_en,
  input  logic                 field_id,
  input  logic [LINE_W-1:0]    line_num,
  input  logic [PIX_W-1:0]     pix_cnt,
  input  logic                 cfg_enable,
  input  logic                 cfg_field,
  input  logic [LINE_W-1:0]    cfg_line,
  input  logic [HOFF_W-1:0]    cfg_hoff,
  input  logic                 ld_valid,
  input  logic [CC_CHAR_W-1:0] ld_char1,
  input  logic [CC_CHAR_W-1:0] ld_char2,
  output logic                 ready,
  output logic                 cc_active,
  output logic                 cc_level
);
  logic      start, last_tick;
  cc_frame_t frame;

  cc_trigger #(.LINE_W(LINE_W), .HOFF_W(HOFF_W), .PIX_W(PIX_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .field_id(field_id),
    .line_num(line_num), .pix_cnt(pix_cnt), .cfg_enable(cfg_enable),
    .cfg_field(cfg_field), .cfg_line(cfg_line), .cfg_hoff(cfg_hoff),
    .busy(cc_active), .start(start));

  cc_holding u_hold (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_char1(ld_char1),
    .ld_char2(ld_char2), .start(start), .last_tick(last_tick),
    .ready(ready), .frame(frame));

  cc_serializer #(.BIT_PIX(BIT_PIX)) u_ser (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .start(start), .frame(frame),
    .active(cc_active), .level(cc_level), .last_tick(last_tick));

  // R2
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cc_active) |-> $past(cfg_enable && pix_en && (line_num == cfg_line)
                               && (field_id == cfg_field)));
  // R9
  no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_active && !cfg_enable && !last_tick) |=> cc_active);
endmodule

// File: tb/tb_cc_line_inserter.sv
`timescale 1ns/1ps
module tb_cc_line_inserter;
  localparam int LINE_W = 6, HOFF_W = 10, PIX_W = 11, BIT_PIX = 4;
  localparam int NBITS = 26;
  localparam int TOTAL = NBITS * BIT_PIX;
  localparam int LINE_PIX = 260;

  logic clk = 0, rst_n = 0, pix_en = 0, field_id = 0;
  logic [LINE_W-1:0] line_num = '0, cfg_line = '0;
  logic [PIX_W-1:0]  pix_cnt = '0;
  logic cfg_enable = 0, cfg_field = 0;
  logic [HOFF_W-1:0] cfg_hoff = '0;
  logic ld_valid = 0;
  logic [6:0] ld_char1 = '0, ld_char2 = '0;
  logic ready, cc_active, cc_level;

  int tests = 0, fails = 0;
  string cur_req = "R3";
  bit done = 0;

  // bench model state
  bit m_active = 0, m_ready = 0, m_pend = 0;
  int m_n = 0;
  logic [NBITS-1:0] m_frame = '0;
  logic [6:0] m_c1 = '0, m_c2 = '0;
  int obs_act = 0, obs_pe = 0;

  always #2.5 clk = ~clk;

  cc_line_inserter #(.LINE_W(LINE_W), .HOFF_W(HOFF_W), .PIX_W(PIX_W), .BIT_PIX(BIT_PIX)) dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .field_id(field_id), .line_num(line_num),
    .pix_cnt(pix_cnt), .cfg_enable(cfg_enable), .cfg_field(cfg_field), .cfg_line(cfg_line),
    .cfg_hoff(cfg_hoff), .ld_valid(ld_valid), .ld_char1(ld_char1), .ld_char2(ld_char2),
    .ready(ready), .cc_active(cc_active), .cc_level(cc_level));

  function automatic logic [NBITS-1:0] tb_frame(logic [6:0] a, logic [6:0] b);
    logic [NBITS-1:0] v = '0;
    int p = 0;
    logic [6:0] ch;
    for (int i = 0; i < 7; i++) begin v[p] = (i % 2 == 0); p++; end
    v[p] = 0; p++; v[p] = 0; p++; v[p] = 1; p++;
    for (int k = 0; k < 2; k++) begin
      ch = (k == 0) ? a : b;
      for (int i = 0; i < 7; i++) begin v[p] = ch[i]; p++; end
      v[p] = ($countones(ch) % 2 == 0); p++;
    end
    return v;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick(bit pe, bit ld, logic [6:0] a, logic [6:0] b);
    bit start, last, was_act;
    logic exp_lvl;
    was_act = cc_active;
    pix_en = pe; ld_valid = ld; ld_char1 = a; ld_char2 = b;
    @(posedge clk);
    start = !m_active && pe && cfg_enable && (field_id == cfg_field) &&
            (line_num == cfg_line) && (pix_cnt == PIX_W'(cfg_hoff));
    last = m_active && pe && (m_n == TOTAL - 1);
    if (m_active && pe) begin
      if (last) m_active = 0; else m_n++;
    end
    if (start) begin
      m_active = 1; m_n = 0;
      m_frame = tb_frame(m_ready ? m_c1 : 7'd0, m_ready ? m_c2 : 7'd0);
    end
    if (ld) begin
      m_ready = 1; m_pend = 0; m_c1 = a; m_c2 = b;
    end else begin
      if (start) m_pend = m_ready;
      if (last && m_pend) begin m_ready = 0; m_pend = 0; end
    end
    @(negedge clk);
    ld_valid = 0;
    exp_lvl = m_active ? m_frame[m_n / BIT_PIX] : 1'b0;
    chk(cc_active == m_active, cur_req, "cc_active", cc_active, m_active);
    chk(cc_level == exp_lvl, cur_req, "cc_level", cc_level, exp_lvl);
    chk(ready == m_ready, "R7", "ready", ready, m_ready);
    if (cc_active) obs_act++;
    if (was_act && pe) obs_pe++;
  endtask

  // one video line; optional load at cycle ld_at, enable cleared at cycle off_at
  task automatic run_line(bit fid, int ln, int pe_pct, int ld_at, logic [6:0] a,
                          logic [6:0] b, int off_at);
    int p = 0, cyc = 0;
    bit pe;
    field_id = fid; line_num = LINE_W'(ln);
    while (p < LINE_PIX) begin
      pix_cnt = PIX_W'(p);
      if (cyc == off_at) cfg_enable = 0;
      pe = (($urandom % 100) < pe_pct);
      tick(pe, cyc == ld_at, a, b);
      if (pe) p++;
      cyc++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(cc_active == 0 && cc_level == 0, "R1", "idle outputs", cc_active + cc_level, 0);
    chk(ready == 0, "R1", "ready after reset", ready, 0);

    // typical setup; load during line 20
    cfg_enable = 1; cfg_field = 0; cfg_line = 6'd21; cfg_hoff = 10'd135;
    cur_req = "R3";
    run_line(0, 20, 100, 10, 7'h41, 7'h62, -1);
    chk(ready == 1, "R6", "ready after load", ready, 1);
    obs_act = 0; obs_pe = 0;
    run_line(0, 21, 100, -1, 0, 0, -1);
    chk(obs_act == TOTAL, "R4", "active cycles", obs_act, TOTAL);
    chk(ready == 0, "R7", "ready after sent pair", ready, 0);
    chk(cc_active == 0 && cc_level == 0, "R5", "idle after burst", cc_active + cc_level, 0);

    // null pair when nothing loaded
    cur_req = "R6";
    obs_act = 0;
    run_line(0, 21, 100, -1, 0, 0, -1);
    chk(obs_act == TOTAL, "R6", "null burst length", obs_act, TOTAL);

    // wrong field: nothing
    cur_req = "R2";
    obs_act = 0;
    run_line(1, 21, 100, -1, 0, 0, -1);
    chk(obs_act == 0, "R2", "wrong field active", obs_act, 0);
    // disabled: nothing, pair kept
    cfg_enable = 0;
    obs_act = 0;
    run_line(0, 21, 100, 5, 7'h7f, 7'h00, -1);
    chk(obs_act == 0, "R2", "disabled active", obs_act, 0);
    chk(ready == 1, "R2", "ready kept while disabled", ready, 1);

    // load in flight keeps ready set
    cfg_enable = 1;
    cur_req = "R8";
    run_line(0, 21, 100, 170, 7'h15, 7'h2a, -1);
    chk(ready == 1, "R8", "ready after mid-burst load", ready, 1);
    run_line(0, 21, 100, -1, 0, 0, -1);
    chk(ready == 0, "R8", "second pair sent", ready, 0);

    // enable dropped mid-burst
    cur_req = "R9";
    obs_act = 0;
    run_line(0, 21, 100, 3, 7'h33, 7'h4c, 180);
    chk(obs_act == TOTAL, "R9", "burst length after enable drop", obs_act, TOTAL);
    cfg_enable = 1;

    // enable gaps, offset zero
    cur_req = "R4";
    cfg_hoff = 10'd0;
    obs_pe = 0;
    run_line(0, 21, 55, 2, 7'h01, 7'h7e, -1);
    chk(obs_pe == TOTAL, "R4", "enabled edges in burst", obs_pe, TOTAL);

    // random mix
    cur_req = "R3";
    for (int ln = 0; ln < 110; ln++) begin
      int ldc;
      if (ln % 10 == 0) begin
        cfg_field = 1'($urandom);
        cfg_line = 6'(19 + $urandom % 5);
        cfg_hoff = 10'($urandom % 151);
      end
      ldc = (($urandom % 3) == 0) ? int'($urandom % 300) : -1;
      run_line(1'($urandom), 19 + $urandom % 5, 50 + $urandom % 51, ldc,
               7'($urandom), 7'($urandom), -1);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule